// File: doc/BRIEF.md
# Synchronous Burst-Fill Read Controller

This block is the bus-master side of a synchronous read. A request carries an address, a transfer size, a function code and a cacheable flag. When it is accepted, the controller raises the address strobe, data strobe and data-buffer enable, and holds the read/write line at read. It then waits for the device to signal termination. Termination is checked on every rising clock edge. Each edge on which termination is found negated adds one wait state.

Once termination is recognized, the long word on the data bus is captured on the next falling clock edge. It is presented with a beat index and a valid flag. On the first beat, the controller also samples the burst-acknowledge and cache-inhibit inputs. These decide whether the transfer stops after one long word or continues as a four-beat burst fill. During a burst the strobes stay asserted and the address attributes stay unchanged. A device with no wait states can complete one beat per clock. After the final long word, a done pulse marks the end and the strobes drop.

Top module: `sync_burst_ctrl`

## Requirements
- R1: After reset, `as_o`, `ds_o`, `dben_o`, `word_valid_o` and `done_o` are all 0.
- R2: While `as_o` is 1, `term_i` is sampled on every rising edge. A value of 1 means termination is asserted. Each rising edge that sees 0 is a wait state, and no word is produced for it.
- R3: The word on `data_i` is captured on the falling edge that follows the rising edge where termination is recognized. It appears on `word_o` with `word_valid_o` = 1 from that falling edge to the next one.
- R4: If the request is cacheable and, at the first recognition, `burst_ack_i` = 1 and `cache_inh_i` = 0, the transfer continues as a burst. It delivers exactly four words with `word_idx_o` = 0, 1, 2, 3 in that order.
- R5: If `cache_inh_i` = 1 at the first recognition, the first word is delivered with `word_nocache_o` = 1 and the transfer ends after that word, whatever `burst_ack_i` is. Levels of `burst_ack_i` and `cache_inh_i` at any other edge have no effect.
- R6: A request with the cacheable flag at 0 ends after one word, even when `burst_ack_i` = 1.
- R7: From acceptance to the end of the transfer, `as_o`, `ds_o` and `dben_o` stay 1. `bus_addr_o`, `bus_size_o` and `bus_fc_o` stay equal to the request values, and `rw_o` stays 1 (read).
- R8: If termination stays asserted on consecutive beats, one burst word is delivered per clock cycle.
- R9: `done_o` is 1 together with the final word of a transfer and at no other time. In that cycle `as_o`, `ds_o` and `dben_o` are already 0.
- R10: Burst beats 2 to 4 follow the same wait-state rule as the first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present; accepted when no transfer is active |
| req_addr_i | input | AW | Request address |
| req_size_i | input | 2 | Request transfer size |
| req_fc_i | input | 3 | Request function code |
| req_cacheable_i | input | 1 | Request may be extended to a burst |
| bus_addr_o | output | AW | Address driven to the bus |
| bus_size_o | output | 2 | Size driven to the bus |
| bus_fc_o | output | 3 | Function code driven to the bus |
| as_o | output | 1 | Address strobe, 1 = asserted |
| ds_o | output | 1 | Data strobe, 1 = asserted |
| dben_o | output | 1 | Data-buffer enable, 1 = asserted |
| rw_o | output | 1 | Read/write line, 1 = read |
| term_i | input | 1 | Synchronous termination, 1 = asserted |
| burst_ack_i | input | 1 | Device agrees to burst, 1 = asserted |
| cache_inh_i | input | 1 | Cache inhibit, 1 = asserted |
| data_i | input | DW | Data bus |
| word_o | output | DW | Captured long word |
| word_idx_o | output | 2 | Beat index of the captured word |
| word_valid_o | output | 1 | Captured word is valid |
| word_nocache_o | output | 1 | Captured word must not be cached |
| done_o | output | 1 | Final word of the transfer |

## Verification
Transfers are run with zero wait states on every beat and with uneven wait counts per beat. While termination is negated the data bus carries a poison value, so a word captured on the wrong edge or during a wait state stands out. The first-beat decision is tried four ways: burst-acknowledge alone, acknowledge with inhibit, no acknowledge, and acknowledge on a non-cacheable request. Acknowledge and inhibit are flipped during wait states, which separates a correct first-recognition sample from a sample taken at the wrong edge. Back-to-back zero-wait beats check the one-word-per-clock rate, and the index and done sequence checks where the burst ends.

// File: rtl/sync_burst_ctrl.sv
module sync_burst_ctrl #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEATS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic [2:0]    req_fc_i,
  input  logic          req_cacheable_i,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  output logic [2:0]    bus_fc_o,
  output logic          as_o,
  output logic          ds_o,
  output logic          dben_o,
  output logic          rw_o,
  input  logic          term_i,
  input  logic          burst_ack_i,
  input  logic          cache_inh_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] word_o,
  output logic [1:0]    word_idx_o,
  output logic          word_valid_o,
  output logic          word_nocache_o,
  output logic          done_o
);
  localparam int IW = 2;
  localparam logic [IW-1:0] LAST_BEAT = IW'(BEATS - 1);

  logic          active_q, cacheable_q;
  logic [IW-1:0] beat_q;
  logic          hit_q, hit_last_q, hit_nc_q;
  logic [IW-1:0] hit_idx_q;

  wire first_beat = (beat_q == '0);
  wire go_burst   = cacheable_q & burst_ack_i & ~cache_inh_i;
  wire last_beat  = (beat_q == LAST_BEAT) | (first_beat & ~go_burst);
  wire recog      = active_q & term_i;

  assign as_o   = active_q;
  assign ds_o   = active_q;
  assign dben_o = active_q;
  assign rw_o   = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      cacheable_q <= 1'b0;
      beat_q      <= '0;
      bus_addr_o  <= '0;
      bus_size_o  <= '0;
      bus_fc_o    <= '0;
      hit_q       <= 1'b0;
      hit_last_q  <= 1'b0;
      hit_nc_q    <= 1'b0;
      hit_idx_q   <= '0;
    end else begin
      hit_q <= recog;
      if (recog) begin
        hit_idx_q  <= beat_q;
        hit_last_q <= last_beat;
        hit_nc_q   <= first_beat & cache_inh_i;
      end
      if (!active_q) begin
        if (req_valid_i) begin
          active_q    <= 1'b1;
          cacheable_q <= req_cacheable_i;
          beat_q      <= '0;
          bus_addr_o  <= req_addr_i;
          bus_size_o  <= req_size_i;
          bus_fc_o    <= req_fc_i;
        end
      end else if (recog) begin
        if (last_beat) active_q <= 1'b0;
        else           beat_q   <= beat_q + 1'b1;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o         <= '0;
      word_idx_o     <= '0;
      word_valid_o   <= 1'b0;
      word_nocache_o <= 1'b0;
      done_o         <= 1'b0;
    end else begin
      word_valid_o <= hit_q;
      done_o       <= hit_q & hit_last_q;
      if (hit_q) begin
        word_o         <= data_i;
        word_idx_o     <= hit_idx_q;
        word_nocache_o <= hit_nc_q;
      end
    end
  end
endmodule

// File: rtl/sync_burst_ctrl_chk.sv
module sync_burst_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          as_o,
  input logic          ds_o,
  input logic          dben_o,
  input logic          term_i,
  input logic [AW-1:0] bus_addr_o,
  input logic [1:0]    bus_size_o,
  input logic [2:0]    bus_fc_o,
  input logic          word_valid_o,
  input logic [1:0]    word_idx_o,
  input logic          done_o
);
  a_r2_wait_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    as_o && !term_i |=> !word_valid_o);

  a_r3_word_follows_term: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(as_o && term_i));

  a_r7_bus_steady: assert property (@(posedge clk) disable iff (!rst_n)
    as_o && $past(as_o) |-> $stable(bus_addr_o) && $stable(bus_size_o) && $stable(bus_fc_o));

  a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o && $past(word_valid_o) |-> word_idx_o == $past(word_idx_o) + 2'd1);

  a_r9_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> word_valid_o && !as_o && !ds_o && !dben_o);
endmodule

bind sync_burst_ctrl sync_burst_ctrl_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .as_o(as_o), .ds_o(ds_o), .dben_o(dben_o),
  .term_i(term_i), .bus_addr_o(bus_addr_o), .bus_size_o(bus_size_o),
  .bus_fc_o(bus_fc_o), .word_valid_o(word_valid_o), .word_idx_o(word_idx_o),
  .done_o(done_o)
);

// File: tb/sync_burst_ctrl_tb_top.sv
module sync_burst_ctrl_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0, req_cacheable_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic [2:0]  req_fc_i = '0;
  logic        term_i = 1'b0, burst_ack_i = 1'b0, cache_inh_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [31:0] bus_addr_o, word_o;
  logic [1:0]  bus_size_o, word_idx_o;
  logic [2:0]  bus_fc_o;
  logic        as_o, ds_o, dben_o, rw_o, word_valid_o, word_nocache_o, done_o;

  sync_burst_ctrl dut_i (.*);

  typedef struct {
    logic [1:0]  idx;
    logic [31:0] data;
    logic        nc;
    logic        done;
    logic        consec;
  } item_t;

  item_t       exp_q[$];
  int          n_checks = 0, n_err = 0, cyc = 0, last_valid_cyc = -10;
  logic [31:0] cur_addr = '0;
  logic [1:0]  cur_size = '0;
  logic [2:0]  cur_fc = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  initial begin
    item_t it;
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (rst_n) begin
        if (as_o) begin
          chk(bus_addr_o == cur_addr && bus_size_o == cur_size && bus_fc_o == cur_fc,
              "R7", "address attributes held", bus_addr_o, cur_addr);
          chk(ds_o && dben_o && rw_o, "R7", "strobes and read line", {ds_o, dben_o, rw_o}, 3'b111);
        end
        if (word_valid_o) begin
          if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected word", word_o, 0);
          else begin
            it = exp_q.pop_front();
            chk(word_idx_o == it.idx, "R4", "beat index", word_idx_o, it.idx);
            chk(word_o == it.data, "R3", "captured data", word_o, it.data);
            chk(word_nocache_o == it.nc, "R5", "nocache flag", word_nocache_o, it.nc);
            chk(done_o == it.done, "R9", "done with word", done_o, it.done);
            if (it.done) chk(!as_o && !ds_o && !dben_o, "R9", "strobes off at done", as_o, 0);
            if (it.consec) chk(last_valid_cyc == cyc - 1, "R8", "back-to-back beat",
                               cyc - last_valid_cyc, 1);
          end
          last_valid_cyc = cyc;
        end else if (done_o) chk(1'b0, "R9", "done without word", 1, 0);
      end
    end
  end

  task automatic run(input logic [31:0] a, input bit c, input bit ack, input bit inh,
                     input int w0, input int w1, input int w2, input int w3,
                     input logic [31:0] seed);
    int w[4];
    int nb;
    item_t it;
    w = '{w0, w1, w2, w3};
    nb = (c && ack && !inh) ? 4 : 1;
    for (int b = 0; b < nb; b++) begin
      it.idx = 2'(b);
      it.data = seed + 32'(b) * 32'h0101_1111;
      it.nc = (b == 0) && inh;
      it.done = (b == nb - 1);
      it.consec = (b > 0) && (w[b] == 0);
      exp_q.push_back(it);
    end
    @(negedge clk); #1;
    req_valid_i = 1'b1; req_addr_i = a; req_cacheable_i = c;
    req_size_i = a[1:0]; req_fc_i = a[6:4];
    cur_addr = a; cur_size = a[1:0]; cur_fc = a[6:4];
    @(posedge clk);
    @(negedge clk); #1;
    req_valid_i = 1'b0;
    for (int b = 0; b < nb; b++) begin
      for (int k = 0; k < w[b]; k++) begin
        term_i = 1'b0; data_i = 32'hBAD0_0000 | 32'(b);
        burst_ack_i = ~ack; cache_inh_i = ~inh;
        @(posedge clk); @(negedge clk); #1;
      end
      term_i = 1'b1; data_i = seed + 32'(b) * 32'h0101_1111;
      burst_ack_i = (b == 0) ? ack : ~ack;
      cache_inh_i = (b == 0) ? inh : ~inh;
      @(posedge clk); @(negedge clk); #1;
    end
    term_i = 1'b0; data_i = 32'hBAD0_00FF; burst_ack_i = 1'b0; cache_inh_i = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    bit timeout = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!as_o && !ds_o && !dben_o, "R1", "strobes after reset", as_o, 0);
    chk(!word_valid_o && !done_o, "R1", "valid and done after reset", word_valid_o, 0);
    fork
      begin
        run(32'h0000_1000, 1'b0, 1'b1, 1'b0, 0, 0, 0, 0, 32'h1111_0000); // R6
        run(32'h0000_2010, 1'b1, 1'b1, 1'b0, 0, 0, 0, 0, 32'h2222_0000); // R4 R8
        run(32'h0000_3021, 1'b1, 1'b1, 1'b0, 2, 0, 3, 1, 32'h3333_0000); // R2 R10
        run(32'h0000_4032, 1'b1, 1'b1, 1'b1, 1, 0, 0, 0, 32'h4444_0000); // R5
        run(32'h0000_5043, 1'b1, 1'b0, 1'b0, 0, 0, 0, 0, 32'h5555_0000); // R4 no ack
        run(32'h0000_6050, 1'b0, 1'b0, 1'b0, 3, 0, 0, 0, 32'h6666_0000); // R2
        run(32'h0000_7061, 1'b1, 1'b1, 1'b0, 0, 4, 0, 2, 32'h7777_0000); // R10 R8
      end
      begin
        repeat (20000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) chk(1'b0, "R2", "watchdog expired", 1, 0);
    chk(exp_q.size() == 0, "R4", "all expected words delivered", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule